// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is a bank of 32 general-purpose pins, grouped as four ports of eight, controlled through a simple synchronous register bus. Each port holds a pin-enable (config) register, an output-enable register, an output-value register, a read-only input sample, an interrupt status register, an interrupt enable register, a three-plane interrupt type register, and a write-only clear register. Software can update single pins through a masked alias of most registers, where the upper byte of the write data chooses which pins change. This avoids a read-modify-write sequence.

Every input pin is synchronized by two flops. The synchronized level is read back through the input register and feeds per-pin edge or level detectors. These detectors set status bits. A single interrupt line is raised while any pin has both its status and enable bits set.

Top module: `pio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all 0 and `irq` is 0.
- R2: A register sits at byte address `port*4 + offset`. The offsets are config 0x00, output enable 0x10, output 0x20, input 0x30, status 0x40, enable 0x50, type 0x60 and clear 0x70. Address bits 10:7 must be 0. Otherwise a write is ignored and a read returns 0.
- R3: `bus_ready` is 1 in the cycle after each cycle with `bus_sel` high, and in that cycle `bus_rdata` holds the read result. A write takes effect at the same clock edge.
- R4: Adding 0x800 to the address selects the masked alias of config, output enable, output, status and enable. Data bit 8+n enables the write of pin n, and data bit n is its new value. Masked writes to the input or clear addresses are ignored.
- R5: A plain type write loads polarity from bits 7:0, edge mode from bits 15:8 and both-edges from bits 23:16, and a read returns the same layout. A masked type write changes only the polarity plane.
- R6: Pin n of port p is bus pin 8p+n. `pin_oe` is 1 only when both its config and output-enable bits are 1. `pin_out` shows the output bit while `pin_oe` is 1 and is 0 otherwise.
- R7: The input register returns the pin levels after a two-flop synchronizer, with pin n at bit n.
- R8: Type codes are written as {both, edge, polarity}. Rising is 011, falling is 010, both edges is 110, level high is 001 and level low is 000. A detected edge sets the pin's status bit, and that bit stays set until it is cleared.
- R9: In level mode the status bit is set in every cycle that the level is active, so a clear has no lasting effect while the level persists. After reset, pins whose inputs are low therefore show status 1.
- R10: Writing 1 to bit n of the clear register clears status bit n, while bits written 0 leave status unchanged. If an edge is detected in the same cycle as the clear, the status bit stays 1.
- R11: `irq` is the OR over all pins of status AND enable.
- R12: Plain writes to the status or input registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is 1 |
| bus_ready | output | 1 | Access completed |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Bank interrupt |

## Verification
The assertions assume that every request is a single-cycle pulse on `bus_sel`. They also assume that the bus is the only path by which status can drop or the pin drive can change. The stimulus keeps to this by holding `bus_sel` for exactly one cycle per access and by changing `pin_in` only between accesses. After each pin change, the bench waits long enough for the synchronizer and the edge register to settle before it predicts status. The one exception is the case where an edge is deliberately made to coincide with a clear.

// File: rtl/pio_pkg.sv
// Shared definitions for the GPIO bank: bus geometry, register selector
// and the decoded write request handed to each port.
package pio_pkg;
    localparam int BUS_DW    = 32;
    localparam int BUS_AW    = 12;
    localparam int ALIAS_BIT = 11;

    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_OE   = 3'd1,
        RG_OUT  = 3'd2,
        RG_IN   = 3'd3,
        RG_STA  = 3'd4,
        RG_EN   = 3'd5,
        RG_TYPE = 3'd6,
        RG_CLR  = 3'd7
    } pio_reg_e;

    typedef struct packed {
        logic              masked;
        pio_reg_e          rsel;
        logic [BUS_DW-1:0] data;
    } pio_wr_t;
endpackage

// File: rtl/pio_sync.sv
// Two-flop synchronizer for asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Capture raw level, then retime once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pio_port.sv
// One port of PINS pins: holds the port registers, applies plain and masked
// writes, and runs per-pin edge/level detection on synchronized inputs.
// Assumes wr_hit is high for one cycle per accepted write to this port.
module pio_port
    import pio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  pio_wr_t         wr,
    input  logic [PINS-1:0] pin_now,
    output logic [PINS-1:0] cfg_q,
    output logic [PINS-1:0] oe_q,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] sta_q,
    output logic [PINS-1:0] en_q,
    output logic [PINS-1:0] pol_q,
    output logic [PINS-1:0] edge_q,
    output logic [PINS-1:0] both_q
);
    localparam int TYPE_W = 3 * PINS;

    logic [PINS-1:0] wval, wena, prev_q, det, clr_vec, sta_base;
    logic            unused_hi;

    assign wval      = wr.data[PINS-1:0];
    assign wena      = wr.data[2*PINS-1:PINS];
    assign unused_hi = ^wr.data[BUS_DW-1:TYPE_W];

    // Plain write replaces; masked write changes only enabled pins.
    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old,
                                              input logic            msk,
                                              input logic [PINS-1:0] v,
                                              input logic [PINS-1:0] e);
        return msk ? ((old & ~e) | (v & e)) : v;
    endfunction

    // Clear strobe: plain write to the clear register only.
    assign clr_vec = (wr_hit && !wr.masked && wr.rsel == RG_CLR) ? wval : '0;

    // Status may be loaded only through its masked alias.
    assign sta_base = (wr_hit && wr.masked && wr.rsel == RG_STA)
                    ? merge(sta_q, 1'b1, wval, wena) : sta_q;

    // Per-pin detector selected by the three type planes.
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign det[i] = edge_q[i]
            ? (both_q[i] ? (pin_now[i] ^ prev_q[i])
                         : (pol_q[i] ? (pin_now[i] & ~prev_q[i])
                                     : (~pin_now[i] & prev_q[i])))
            : ~(pin_now[i] ^ pol_q[i]);
    end

    // Configuration and interrupt control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            oe_q   <= '0;
            out_q  <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            both_q <= '0;
        end else if (wr_hit) begin
            case (wr.rsel)
                RG_CFG: cfg_q <= merge(cfg_q, wr.masked, wval, wena);
                RG_OE:  oe_q  <= merge(oe_q,  wr.masked, wval, wena);
                RG_OUT: out_q <= merge(out_q, wr.masked, wval, wena);
                RG_EN:  en_q  <= merge(en_q,  wr.masked, wval, wena);
                RG_TYPE: begin
                    if (wr.masked) begin
                        pol_q <= merge(pol_q, 1'b1, wval, wena);
                    end else begin
                        {both_q, edge_q, pol_q} <= wr.data[TYPE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // Status: detection beats clear, clear beats held value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q  <= '0;
            prev_q <= '0;
        end else begin
            sta_q  <= det | (~clr_vec & sta_base);
            prev_q <= pin_now;
        end
    end
endmodule

// File: rtl/pio_bank.sv
// GPIO bank of NUM_PORTS ports x PINS pins on a one-cycle register bus.
// Decodes the address, fans writes out to the ports, registers read data
// and combines interrupts. Assumes NUM_PORTS <= 4 and 3*PINS < 32.
module pio_bank
    import pio_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic [BUS_DW-1:0]           bus_wdata,
    output logic [BUS_DW-1:0]           bus_rdata,
    output logic                        bus_ready,
    input  logic [NUM_PORTS*PINS-1:0]   pin_in,
    output logic [NUM_PORTS*PINS-1:0]   pin_out,
    output logic [NUM_PORTS*PINS-1:0]   pin_oe,
    output logic                        irq
);
    localparam int NPINS = NUM_PORTS * PINS;

    logic [NPINS-1:0]                sync_in;
    logic [NUM_PORTS-1:0][PINS-1:0]  cfg_a, oe_a, out_a, sta_a, en_a, pol_a, edg_a, bth_a;
    logic [NPINS-1:0]                sta_flat;
    logic [1:0]                      port_idx;
    logic                            addr_ok;
    logic                            unused_lsb;
    pio_wr_t                         wr;
    logic [BUS_DW-1:0]               rd_word;

    assign port_idx   = bus_addr[3:2];
    assign addr_ok    = (bus_addr[10:7] == 4'd0) && (int'(port_idx) < NUM_PORTS);
    assign unused_lsb = ^bus_addr[1:0];
    assign wr         = '{masked: bus_addr[ALIAS_BIT],
                          rsel:   pio_reg_e'(bus_addr[6:4]),
                          data:   bus_wdata};

    pio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_in)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic hit;
        assign hit = bus_sel && bus_we && addr_ok && (int'(port_idx) == g);

        pio_port #(.PINS(PINS)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .wr      (wr),
            .pin_now (sync_in[g*PINS +: PINS]),
            .cfg_q   (cfg_a[g]),
            .oe_q    (oe_a[g]),
            .out_q   (out_a[g]),
            .sta_q   (sta_a[g]),
            .en_q    (en_a[g]),
            .pol_q   (pol_a[g]),
            .edge_q  (edg_a[g]),
            .both_q  (bth_a[g])
        );

        assign pin_oe[g*PINS +: PINS]  = cfg_a[g] & oe_a[g];
        assign pin_out[g*PINS +: PINS] = cfg_a[g] & oe_a[g] & out_a[g];
    end

    assign sta_flat = sta_a;
    assign irq      = |(sta_a & en_a);

    // Read multiplexer; masked alias reads return the plain register.
    always_comb begin
        rd_word = '0;
        case (wr.rsel)
            RG_CFG:  rd_word[PINS-1:0]   = cfg_a[port_idx];
            RG_OE:   rd_word[PINS-1:0]   = oe_a[port_idx];
            RG_OUT:  rd_word[PINS-1:0]   = out_a[port_idx];
            RG_IN:   rd_word[PINS-1:0]   = sync_in[int'(port_idx)*PINS +: PINS];
            RG_STA:  rd_word[PINS-1:0]   = sta_a[port_idx];
            RG_EN:   rd_word[PINS-1:0]   = en_a[port_idx];
            RG_TYPE: rd_word[3*PINS-1:0] = {bth_a[port_idx], edg_a[port_idx], pol_a[port_idx]};
            default: rd_word = '0;
        endcase
    end

    // Single-cycle bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_ready <= 1'b0;
        end else begin
            bus_ready <= bus_sel;
            bus_rdata <= (bus_sel && !bus_we && addr_ok) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/pio_bank_chk.sv
// Protocol and state checks for pio_bank, attached with bind.
// Assumes requests are single-cycle pulses on bus_sel.
module pio_bank_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic             bus_ready,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] sta_all
);
    // R3: a request is answered in the next cycle
    a_r3_ready_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    // R3: no response without a request
    a_r3_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_ready);

    // R6: a pin is never driven high while its drive is off
    a_r6_out_within_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R4: drive state changes only after a bus write
    a_r4_pins_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_we) |-> ($stable(pin_out) && $stable(pin_oe)));

    // R10: a status bit drops only after a bus write
    for (genvar i = 0; i < NPINS; i++) begin : g_sta
        a_r10_status_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sta_all[i]) |-> $past(bus_sel && bus_we));
    end
endmodule

bind pio_bank pio_bank_chk #(.NPINS(NUM_PORTS * PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .sta_all   (sta_flat)
);

// File: tb/tb_pio_bank.sv
`timescale 1ns/1ps
// Self-checking bench for pio_bank: directed corners plus seeded random
// interrupt-type and pin patterns checked against a transaction model.
module tb_pio_bank;
    localparam int R_CFG = 0, R_OE = 1, R_OUT = 2, R_IN = 3;
    localparam int R_STA = 4, R_EN = 5, R_TYPE = 6, R_CLR = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;
    logic [31:0] pin_in, pin_out, pin_oe;
    logic        irq;

    int nchecks = 0;
    int nerr    = 0;

    logic [7:0] m_pol [4];
    logic [7:0] m_edg [4];
    logic [7:0] m_bth [4];
    logic [7:0] m_en  [4];
    logic [7:0] m_sta [4];
    logic [31:0] cur_in;

    always #2 clk = ~clk;

    pio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [11:0] ra(int rg, int port, bit msk);
        return {msk, 4'b0000, rg[2:0], port[1:0], 2'b00};
    endfunction

    // Level-mode pins whose level is active (R9).
    function automatic logic [7:0] lvl_act(logic [7:0] pol, logic [7:0] edg, logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = !edg[i] && (v[i] == pol[i]);
        return r;
    endfunction

    // Edge-mode pins that see their edge (R8).
    function automatic logic [7:0] edge_evt(logic [7:0] pol, logic [7:0] edg, logic [7:0] bth,
                                           logic [7:0] o, logic [7:0] n);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (!edg[i])     r[i] = 1'b0;
            else if (bth[i]) r[i] = o[i] != n[i];
            else if (pol[i]) r[i] = !o[i] && n[i];
            else             r[i] = o[i] && !n[i];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        chk("R3 ready", {31'b0, bus_ready}, 32'd1);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  m;
        void'($urandom(32'd7741));
        pin_in = '0; cur_in = '0; rst_n = 1'b0;
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 pin_oe", pin_oe, 32'd0);
        for (int p = 0; p < 4; p++) begin
            rd_chk("R1 cfg", ra(R_CFG, p, 0), 32'd0);
            rd_chk("R1 oe", ra(R_OE, p, 0), 32'd0);
            rd_chk("R1 out", ra(R_OUT, p, 0), 32'd0);
            rd_chk("R1 en", ra(R_EN, p, 0), 32'd0);
            rd_chk("R1 type", ra(R_TYPE, p, 0), 32'd0);
            rd_chk("R9 level-low status after reset", ra(R_STA, p, 0), 32'h0000_00FF);
        end

        // R2: addresses outside bank 0 are ignored and read as 0
        wr(ra(R_CFG, 0, 0) | 12'h080, 32'hFF);
        rd_chk("R2 foreign write ignored", ra(R_CFG, 0, 0), 32'd0);
        rd_chk("R2 foreign read zero", ra(R_STA, 0, 0) | 12'h080, 32'd0);

        // R6 and R4: drive logic and masked writes on port 1
        wr(ra(R_CFG, 1, 0), 32'hF0);
        wr(ra(R_OE, 1, 0), 32'h3C);
        wr(ra(R_OUT, 1, 0), 32'hAA);
        chk("R6 pin_oe", pin_oe, 32'h0000_3000);
        chk("R6 pin_out", pin_out, 32'h0000_2000);
        wr(ra(R_OUT, 1, 1), 32'h0F05);
        rd_chk("R4 masked out", ra(R_OUT, 1, 0), 32'hA5);
        wr(ra(R_OE, 1, 1), 32'h00FF);
        rd_chk("R4 masked enable zero keeps", ra(R_OE, 1, 0), 32'h3C);
        chk("R6 pin_out after masked", pin_out, 32'h0000_2000);
        wr(ra(R_CFG, 1, 1), 32'h0404);
        chk("R6 pin_oe after masked cfg", pin_oe, 32'h0000_3400);
        chk("R6 pin_out after masked cfg", pin_out, 32'h0000_2400);

        // R4 and R12: status aliases on port 2 (level high, inputs low)
        wr(ra(R_TYPE, 2, 0), 32'h0000_00FF);
        wr(ra(R_CLR, 2, 0), 32'hFF);
        rd_chk("R9 inactive level clears", ra(R_STA, 2, 0), 32'd0);
        wr(ra(R_STA, 2, 1), 32'h0F05);
        rd_chk("R4 masked status load", ra(R_STA, 2, 0), 32'h05);
        wr(ra(R_STA, 2, 0), 32'hFF);
        rd_chk("R12 plain status write ignored", ra(R_STA, 2, 0), 32'h05);
        wr(ra(R_CLR, 2, 1), 32'hFFFF);
        rd_chk("R4 masked clear alias ignored", ra(R_STA, 2, 0), 32'h05);
        wr(ra(R_IN, 2, 0), 32'hFF);
        rd_chk("R12 input write ignored", ra(R_IN, 2, 0), 32'd0);
        wr(ra(R_EN, 2, 0), 32'h04);
        chk("R11 irq on status and enable", {31'b0, irq}, 32'd1);
        wr(ra(R_EN, 2, 0), 32'h02);
        chk("R11 irq off when disjoint", {31'b0, irq}, 32'd0);
        wr(ra(R_EN, 2, 0), 32'h00);

        // R5: type register layout and masked polarity update
        wr(ra(R_TYPE, 3, 0), 32'h00FF_FF00);
        rd_chk("R5 plain type", ra(R_TYPE, 3, 0), 32'h00FF_FF00);
        wr(ra(R_TYPE, 3, 1), 32'h0F0A);
        rd_chk("R5 masked type polarity only", ra(R_TYPE, 3, 0), 32'h00FF_FF0A);

        // R7: synchronized input readback
        cur_in = 32'hA5C3_3C5A; pin_in = cur_in;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 4; p++)
            rd_chk("R7 input", ra(R_IN, p, 0), {24'b0, cur_in[p*8 +: 8]});

        // R10: both-edge pin 0 of port 0, clear and coincident edge
        wr(ra(R_TYPE, 0, 0), 32'h0001_0100);
        repeat (3) @(negedge clk);
        wr(ra(R_CLR, 0, 0), 32'h01);
        rd(ra(R_STA, 0, 0), d);
        chk("R10 clear edge status", {31'b0, d[0]}, 32'd0);
        cur_in[0] = ~cur_in[0]; pin_in = cur_in;
        repeat (4) @(negedge clk);
        rd(ra(R_STA, 0, 0), d);
        chk("R8 both-edge sets", {31'b0, d[0]}, 32'd1);
        wr(ra(R_CLR, 0, 0), 32'h00);
        rd(ra(R_STA, 0, 0), d);
        chk("R10 zero clear no effect", {31'b0, d[0]}, 32'd1);
        cur_in[0] = ~cur_in[0]; pin_in = cur_in;
        repeat (2) @(negedge clk);
        wr(ra(R_CLR, 0, 0), 32'h01);
        rd(ra(R_STA, 0, 0), d);
        chk("R10 edge wins over clear", {31'b0, d[0]}, 32'd1);

        // R9: level-high pin 3 of port 1 persists through clear
        wr(ra(R_TYPE, 1, 0), 32'h08);
        cur_in[11] = 1'b1; pin_in = cur_in;
        repeat (4) @(negedge clk);
        wr(ra(R_CLR, 1, 0), 32'h08);
        rd(ra(R_STA, 1, 0), d);
        chk("R9 active level survives clear", {31'b0, d[3]}, 32'd1);
        cur_in[11] = 1'b0; pin_in = cur_in;
        repeat (4) @(negedge clk);
        wr(ra(R_CLR, 1, 0), 32'h08);
        rd(ra(R_STA, 1, 0), d);
        chk("R9 inactive level clears", {31'b0, d[3]}, 32'd0);

        // Random interrupt types and pin patterns: R8, R9, R10, R11
        for (int it = 0; it < 40; it++) begin
            for (int p = 0; p < 4; p++) begin
                for (int i = 0; i < 8; i++) begin
                    case ($urandom % 5)
                        0: {m_bth[p][i], m_edg[p][i], m_pol[p][i]} = 3'b000;
                        1: {m_bth[p][i], m_edg[p][i], m_pol[p][i]} = 3'b001;
                        2: {m_bth[p][i], m_edg[p][i], m_pol[p][i]} = 3'b011;
                        3: {m_bth[p][i], m_edg[p][i], m_pol[p][i]} = 3'b010;
                        default: {m_bth[p][i], m_edg[p][i], m_pol[p][i]} = 3'b110;
                    endcase
                end
                m_en[p] = 8'($urandom);
                wr(ra(R_TYPE, p, 0), {8'b0, m_bth[p], m_edg[p], m_pol[p]});
                wr(ra(R_EN, p, 0), {24'b0, m_en[p]});
            end
            for (int p = 0; p < 4; p++) begin
                wr(ra(R_CLR, p, 0), 32'hFF);
                m_sta[p] = lvl_act(m_pol[p], m_edg[p], cur_in[p*8 +: 8]);
            end
            pin_in = $urandom;
            repeat (5) @(negedge clk);
            for (int p = 0; p < 4; p++)
                m_sta[p] = m_sta[p]
                         | edge_evt(m_pol[p], m_edg[p], m_bth[p], cur_in[p*8 +: 8], pin_in[p*8 +: 8])
                         | lvl_act(m_pol[p], m_edg[p], pin_in[p*8 +: 8]);
            cur_in = pin_in;
            for (int p = 0; p < 4; p++)
                rd_chk("R8 random status", ra(R_STA, p, 0), {24'b0, m_sta[p]});
            chk("R11 random irq", {31'b0, irq},
                {31'b0, |((m_sta[0] & m_en[0]) | (m_sta[1] & m_en[1]) |
                          (m_sta[2] & m_en[2]) | (m_sta[3] & m_en[3]))});
            for (int p = 0; p < 4; p++) begin
                m = 8'($urandom);
                wr(ra(R_CLR, p, 0), {24'b0, m});
                m_sta[p] = (m_sta[p] & ~m) | lvl_act(m_pol[p], m_edg[p], cur_in[p*8 +: 8]);
                rd_chk("R10 random clear", ra(R_STA, p, 0), {24'b0, m_sta[p]});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule